// File: doc/BRIEF.md
# Timer Output Compare Modulator

This block produces a single pin output by merging two waveforms made by two small on-block timers. The carrier timer counts up to a programmable limit, restarts at zero and flips its output each time it restarts, so its output is a square wave. The modulating timer is a single-slope PWM generator. Its output is high from the start of each period until its count passes a programmable compare value.

A pin control register selects how the two registered waveforms are merged. One bit picks a logical AND or a logical OR. The result is registered once more before it drives the pin, and a second bit enables the pin driver. While the driver is off the pad is left floating.

Because the merged output can only change where the carrier allows it, the PWM duty cycle seen on the pin moves in steps of a whole carrier period and not one clock. Software writes the limits through a plain write strobe with a two-bit register select. Timer values are staged and take effect only at a period boundary, so a period is never cut short or stretched by a write.

Top module: `wave_modulator`

## Requirements
- R1: While `rst` is high at a rising edge, both counters, both waveform flip-flops, all staged and active limits, the pin control register and the pin register are cleared, so after that edge `pin_o` = 0 and `pin_oe` = 0.
- R2: The carrier counter runs from 0 up to its active limit C and then returns to 0. The carrier flip-flop inverts on every return to 0, which gives a carrier period of 2×(C+1) clocks.
- R3: The PWM counter runs from 0 up to its active TOP and then returns to 0. The PWM flip-flop is loaded with 1 while the count is at most the active compare value K and with 0 otherwise, so K = 0 gives one high clock per period and K ≥ TOP gives a constant high.
- R4: A write with `wr_sel` = 0 (carrier limit), 1 (PWM TOP) or 2 (PWM compare) only updates a staged copy. The staged copy becomes active on the clock edge where that counter returns to 0.
- R5: A write with `wr_sel` = 3 updates the pin control register at once. Bit 0 selects the merge: 0 gives AND of the two waveform flip-flops and 1 gives OR. The pin register loads the merge one edge later, so a merge change reaches `pin_o` on the second edge after the write.
- R6: Bit 1 of the pin control register is the driver enable and is output on `pin_oe` from the edge of the write onward. While it is 0 the pad is undriven.
- R7: With a two-clock carrier (C = 0), TOP = 7 and AND merging, the pin's high time per PWM period takes at most 5 distinct values over the 8 compare settings 0 to 7, and it is half the period when K = TOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 carrier limit, 1 PWM TOP, 2 PWM compare, 3 pin control |
| wr_data | input | DW | Write data, DW = max(CW, PW); pin control uses bit 0 (merge OR) and bit 1 (driver enable) |
| pin_o | output | 1 | Registered merged waveform toward the pad |
| pin_oe | output | 1 | Pad driver enable; pad is high impedance when 0 |

## Verification
A write to the pin control register changes `pin_oe` on the next edge and changes the merged value on `pin_o` on the edge after that. A timer write first waits for its counter to return to 0, then passes through the waveform flip-flop and the pin register, so it shows on the pin two edges after that counter's next wrap. The bench keeps a cycle model built from the requirements. Each time it drives inputs on a falling edge, it queues the pin value and enable that are due after the next rising edge. A monitor compares the queued entry with the ports 2 ns after that edge. The directed measurements of period, duty and resolution count only after a settling time longer than these latencies.

// File: rtl/wmod_pkg.sv
package wmod_pkg;

    typedef enum logic [1:0] {
        SEL_CARRIER_LIM = 2'd0,
        SEL_PWM_TOP     = 2'd1,
        SEL_PWM_CMP     = 2'd2,
        SEL_PIN_CTRL    = 2'd3
    } reg_sel_e;

    localparam int PIN_MERGE_BIT = 0;
    localparam int PIN_DRIVE_BIT = 1;

    typedef struct packed {
        logic drive_en;
        logic merge_or;
    } pin_ctrl_t;

    typedef struct packed {
        logic carrier;
        logic pwm;
    } wave_pair_t;

    typedef struct packed {
        logic ld_carrier;
        logic ld_top;
        logic ld_cmp;
    } load_strobes_t;

    function automatic logic merge_waves(input wave_pair_t w, input logic use_or);
        return use_or ? (w.carrier | w.pwm) : (w.carrier & w.pwm);
    endfunction

endpackage

// File: rtl/wmod_regdec.sv
module wmod_regdec
    import wmod_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    output load_strobes_t loads,
    output pin_ctrl_t     ctrl
);

    reg_sel_e sel;
    assign sel = reg_sel_e'(wr_sel);

    always_comb begin
        loads = '0;
        if (wr_en) begin
            case (sel)
                SEL_CARRIER_LIM: loads.ld_carrier = 1'b1;
                SEL_PWM_TOP:     loads.ld_top     = 1'b1;
                SEL_PWM_CMP:     loads.ld_cmp     = 1'b1;
                default:         loads            = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_en && sel == SEL_PIN_CTRL) begin
            ctrl.merge_or <= wr_data[PIN_MERGE_BIT];
            ctrl.drive_en <= wr_data[PIN_DRIVE_BIT];
        end
    end

    // R6: pin control takes a write on the very next edge
    a_r6_ctrl_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd3) |=> (ctrl.drive_en == $past(wr_data[PIN_DRIVE_BIT])))
        else $error("a_r6_ctrl_write");

    a_r5_ctrl_hold: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_sel == 2'd3) |=> $stable(ctrl))
        else $error("a_r5_ctrl_hold");

endmodule

// File: rtl/wmod_carrier.sv
module wmod_carrier #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic         wave_q
);

    logic [W-1:0] cnt;
    logic [W-1:0] lim_staged;
    logic [W-1:0] lim_active;
    logic         wrap;

    assign wrap = (cnt == lim_active);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= '0;
            lim_staged <= '0;
            lim_active <= '0;
            wave_q     <= 1'b0;
        end else begin
            if (ld) begin
                lim_staged <= ld_val;
            end
            if (wrap) begin
                cnt        <= '0;
                lim_active <= lim_staged;
                wave_q     <= ~wave_q;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    a_r2_flip_on_wrap: assert property (@(posedge clk) disable iff (rst)
        (cnt == lim_active) |=> (wave_q != $past(wave_q)))
        else $error("a_r2_flip_on_wrap");

    a_r2_hold_mid_period: assert property (@(posedge clk) disable iff (rst)
        (cnt != lim_active) |=> $stable(wave_q))
        else $error("a_r2_hold_mid_period");

    a_r4_carrier_staged: assert property (@(posedge clk) disable iff (rst)
        (cnt != lim_active) |=> $stable(lim_active))
        else $error("a_r4_carrier_staged");

endmodule

// File: rtl/wmod_pwm.sv
module wmod_pwm #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld_top,
    input  logic         ld_cmp,
    input  logic [W-1:0] ld_val,
    output logic         wave_q
);

    logic [W-1:0] cnt;
    logic [W-1:0] top_staged;
    logic [W-1:0] top_active;
    logic [W-1:0] cmp_staged;
    logic [W-1:0] cmp_active;
    logic         wrap;
    logic         level;

    assign wrap  = (cnt == top_active);
    assign level = (cnt <= cmp_active);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= '0;
            top_staged <= '0;
            top_active <= '0;
            cmp_staged <= '0;
            cmp_active <= '0;
            wave_q     <= 1'b0;
        end else begin
            if (ld_top) begin
                top_staged <= ld_val;
            end
            if (ld_cmp) begin
                cmp_staged <= ld_val;
            end
            if (wrap) begin
                cnt        <= '0;
                top_active <= top_staged;
                cmp_active <= cmp_staged;
            end else begin
                cnt <= cnt + 1'b1;
            end
            wave_q <= level;
        end
    end

    a_r3_set_at_start: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0) |=> wave_q)
        else $error("a_r3_set_at_start");

    a_r3_clear_after_cmp: assert property (@(posedge clk) disable iff (rst)
        (cnt > cmp_active) |=> !wave_q)
        else $error("a_r3_clear_after_cmp");

    a_r3_count_bounded: assert property (@(posedge clk) disable iff (rst)
        (cnt <= top_active) |=> (cnt <= top_active))
        else $error("a_r3_count_bounded");

    a_r4_pwm_staged: assert property (@(posedge clk) disable iff (rst)
        (cnt != top_active) |=> ($stable(top_active) && $stable(cmp_active)))
        else $error("a_r4_pwm_staged");

endmodule

// File: rtl/wmod_pin_stage.sv
module wmod_pin_stage
    import wmod_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  wave_pair_t waves,
    input  pin_ctrl_t  ctrl,
    output logic       pin_q,
    output logic       pin_oe
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q <= 1'b0;
        end else begin
            pin_q <= merge_waves(waves, ctrl.merge_or);
        end
    end

    assign pin_oe = ctrl.drive_en;

    // R5: AND gating blocks the pin whenever either waveform is low
    a_r5_and_gate: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.merge_or && !(waves.carrier && waves.pwm)) |=> !pin_q)
        else $error("a_r5_and_gate");

    // R5: OR merging passes any high waveform
    a_r5_or_pass: assert property (@(posedge clk) disable iff (rst)
        (ctrl.merge_or && (waves.carrier || waves.pwm)) |=> pin_q)
        else $error("a_r5_or_pass");

endmodule

// File: rtl/wave_modulator.sv
module wave_modulator
    import wmod_pkg::*;
#(
    parameter  int CW = 8,
    parameter  int PW = 8,
    localparam int DW = (CW > PW) ? CW : PW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic          pin_o,
    output logic          pin_oe
);

    load_strobes_t loads;
    pin_ctrl_t     ctrl;
    wave_pair_t    waves;

    wmod_regdec #(.DW(DW)) u_regdec (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .loads   (loads),
        .ctrl    (ctrl)
    );

    wmod_carrier #(.W(CW)) u_carrier (
        .clk    (clk),
        .rst    (rst),
        .ld     (loads.ld_carrier),
        .ld_val (wr_data[CW-1:0]),
        .wave_q (waves.carrier)
    );

    wmod_pwm #(.W(PW)) u_pwm (
        .clk    (clk),
        .rst    (rst),
        .ld_top (loads.ld_top),
        .ld_cmp (loads.ld_cmp),
        .ld_val (wr_data[PW-1:0]),
        .wave_q (waves.pwm)
    );

    wmod_pin_stage u_pin (
        .clk    (clk),
        .rst    (rst),
        .waves  (waves),
        .ctrl   (ctrl),
        .pin_q  (pin_o),
        .pin_oe (pin_oe)
    );

    // R1: reset leaves the pin undriven and low
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!pin_o && !pin_oe))
        else $error("a_r1_reset_clear");

    a_r6_enable_port: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd3) |=> (pin_oe == $past(wr_data[PIN_DRIVE_BIT])))
        else $error("a_r6_enable_port");

endmodule

// File: tb/wave_modulator_test.sv
module wave_modulator_test;

    localparam int CW = 8;
    localparam int PW = 8;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = 2'd0;
    logic [DW-1:0] wr_data = '0;
    logic          pin_o;
    logic          pin_oe;

    always #4 clk = ~clk;

    wave_modulator #(.CW(CW), .PW(PW)) uut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .pin_o   (pin_o),
        .pin_oe  (pin_oe)
    );

    typedef struct {
        logic  pin;
        logic  oe;
        string tag;
    } exp_t;

    exp_t  sbq[$];
    string phase = "R1";
    int    checks = 0;
    int    fails = 0;
    logic  seen_pin = 1'b0;
    bit    done = 1'b0;

    // requirement-level model state
    int m_ccnt, m_csh, m_cact, m_pcnt, m_tsh, m_tact, m_ksh, m_kact;
    bit m_cq, m_pq, m_pin, m_dir, m_or;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input bit we, input int sel, input int data, input bit r);
        bit cwrap, pwrap, pnext, plevel;
        @(negedge clk);
        seen_pin = pin_o;
        rst     = r;
        wr_en   = we;
        wr_sel  = sel[1:0];
        wr_data = data[DW-1:0];
        if (r) begin
            m_ccnt = 0; m_csh = 0; m_cact = 0; m_cq = 0;
            m_pcnt = 0; m_tsh = 0; m_tact = 0; m_ksh = 0; m_kact = 0; m_pq = 0;
            m_pin = 0; m_dir = 0; m_or = 0;
        end else begin
            cwrap  = (m_ccnt == m_cact);
            pwrap  = (m_pcnt == m_tact);
            pnext  = m_or ? (m_cq | m_pq) : (m_cq & m_pq);
            plevel = (m_pcnt <= m_kact);
            if (cwrap) begin m_ccnt = 0; m_cact = m_csh; m_cq = !m_cq; end
            else m_ccnt++;
            if (pwrap) begin m_pcnt = 0; m_tact = m_tsh; m_kact = m_ksh; end
            else m_pcnt++;
            m_pq  = plevel;
            m_pin = pnext;
            if (we) begin
                case (sel)
                    0: m_csh = data & 8'hFF;
                    1: m_tsh = data & 8'hFF;
                    2: m_ksh = data & 8'hFF;
                    default: begin m_or = data[0]; m_dir = data[1]; end
                endcase
            end
        end
        sbq.push_back('{m_pin, m_dir, phase});
    endtask

    task automatic idle(input int n);
        repeat (n) step(1'b0, 0, 0, 1'b0);
    endtask

    task automatic wr(input int sel, input int data);
        step(1'b1, sel, data, 1'b0);
    endtask

    task automatic count_high(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            idle(1);
            if (seen_pin) hi++;
        end
    endtask

    // monitor: compare scoreboard entries 2 ns after each rising edge
    always @(posedge clk) begin
        exp_t e;
        #2;
        if (sbq.size() > 0) begin
            e = sbq.pop_front();
            checks++;
            if (pin_o !== e.pin || pin_oe !== e.oe) begin
                fails++;
                $display("FAIL %s: actual pin=%b oe=%b expected pin=%b oe=%b",
                         e.tag, pin_o, pin_oe, e.pin, e.oe);
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int hi, rises, lvl, distinct;
        int h[8];
        bit mono;
        bit prev;

        // R1 reset state
        phase = "R1";
        repeat (3) step(1'b0, 0, 0, 1'b1);
        chk("R1 pin_o after reset", pin_o, 0);
        chk("R1 pin_oe after reset", pin_oe, 0);

        // R2 carrier period with PWM constant high (reset TOP=0, K=0), AND merge
        phase = "R2";
        wr(3, 2);
        wr(0, 2);
        idle(20);
        rises = 0;
        prev = pin_o;
        for (int i = 0; i < 24; i++) begin
            idle(1);
            if (seen_pin && !prev) rises++;
            prev = seen_pin;
        end
        chk("R2 carrier rises in 24 clocks (C=2)", rises, 4);
        chk("R6 pin_oe with drive bit set", pin_oe, 1);

        // R3 PWM duty inside a long carrier half-period
        phase = "R3";
        wr(0, 255);
        idle(6);
        lvl = pin_o;
        wr(3, (lvl != 0) ? 2 : 3);
        wr(1, 7);
        wr(2, 0);
        idle(20);
        count_high(16, hi);
        chk("R3 K=0 gives one high clock per period", hi, 2);
        wr(2, 7);
        idle(20);
        count_high(16, hi);
        chk("R3 K=TOP gives constant high", hi, 16);
        wr(2, 3);
        idle(20);
        count_high(16, hi);
        chk("R3 K=3 gives four high clocks per period", hi, 8);

        // R5 OR merge with PWM constant high
        phase = "R5";
        wr(2, 7);
        wr(3, 3);
        idle(20);
        count_high(16, hi);
        chk("R5 OR merge with PWM high", hi, 16);
        wr(3, 2);
        idle(4);

        // R4 staged writes at awkward moments, checked by scoreboard
        phase = "R4";
        wr(0, 1);
        wr(1, 5);
        for (int i = 0; i < 60; i++) begin
            if (i % 7 == 3) wr(2, i % 6);
            else if (i % 11 == 5) wr(1, 3 + i % 4);
            else if (i % 13 == 8) wr(0, i % 3);
            else if (i % 17 == 9) wr(3, 2 + (i % 2));
            else idle(1);
        end

        // R6 driver enable on and off
        phase = "R6";
        wr(3, 0);
        idle(1);
        chk("R6 pin_oe cleared by drive bit 0", pin_oe, 0);
        wr(3, 2);
        idle(1);
        chk("R6 pin_oe set by drive bit 1", pin_oe, 1);

        // R7 resolution quantised by the two-clock carrier
        phase = "R7";
        wr(0, 0);
        wr(1, 7);
        wr(3, 2);
        for (int k = 0; k < 8; k++) begin
            wr(2, k);
            idle(24);
            count_high(16, hi);
            h[k] = hi / 2;
        end
        distinct = 1;
        mono = 1'b1;
        for (int k = 1; k < 8; k++) begin
            if (h[k] != h[k-1]) distinct++;
            if (h[k] < h[k-1]) mono = 1'b0;
        end
        chk("R7 distinct high times over 8 settings at most 5", (distinct <= 5) ? 1 : 0, 1);
        chk("R7 high time never falls as K rises", mono, 1);
        chk("R7 K=TOP shows half-period carrier", h[7], 4);

        idle(3);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule